// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block owns three transmit mailboxes of a CAN controller. Software writes an identifier into a free mailbox and raises a transmit request in the same cycle. The block records each mailbox's state, picks which pending mailbox the bus-side engine sends next, and resolves abort requests. A start/done/success handshake connects it to the engine. Per-mailbox flags report completion, success and failed attempts.

One mode input chooses the order. With `orderFifo` high, pending mailboxes leave in the order their requests were accepted. With it low, the lowest aligned identifier leaves first, and on equal identifiers the lower mailbox index wins. An abort of a waiting mailbox frees it at once. An abort of the mailbox on the bus is held until the engine reports the outcome. A failed attempt with no abort puts the mailbox back in the queue, so it is retried automatically.

Top module: `can_txmb_sched`

## Requirements
- R1: A request (`reqValid` with `reqIdx`) to a free mailbox (`mbEmpty` bit 1) is accepted. One cycle later that mailbox is not free and its `doneFlag`, `okFlag` and `errFlag` bits are 0. A request to a mailbox that is not free is ignored, and its stored identifier and state do not change.
- R2: At most one mailbox is in transmit at a time. `busStart` is a one-cycle pulse. When the engine is idle, it rises in the second cycle after a request is accepted. After that it rises again only once `busDone` has been seen.
- R3: With `orderFifo` = 1, pending mailboxes are started in the order their requests were accepted.
- R4: With `orderFifo` = 0, the pending mailbox with the numerically lowest aligned identifier is started first.
- R5: With `orderFifo` = 0 and equal identifiers, the lower mailbox index is started first.
- R6: Identifiers are 29 bits wide. When `reqExt` = 0, `reqId[10:0]` is stored in bits 28:18 and the lower bits are zero. `busId` shows the stored aligned identifier of the mailbox being sent.
- R7: An abort (`abortReq` bit) of a scheduled mailbox takes effect in the next cycle. The mailbox is then free, with `doneFlag` = 1 and `okFlag` = 0, and it is never started.
- R8: A successful transmission (`busDone` with `busOk` = 1) frees the mailbox and sets `doneFlag` and `okFlag` in the next cycle. An abort raised while the mailbox is in transmit is held, so the mailbox stays occupied until `busDone`, and a success then resolves it the same way.
- R9: A failed transmission of a mailbox whose abort is held frees it, with `doneFlag` = 1, `okFlag` = 0 and `errFlag` = 1, and the mailbox is not restarted.
- R10: A failed transmission with no abort sets `errFlag` and returns the mailbox to scheduled. The current ordering rule then retries it; in request-order mode it keeps its original place in the queue.
- R11: When a mailbox leaves the queue by completion or abort, the remaining pending mailboxes keep their relative order. A mailbox requested later joins the queue at the end.
- R12: After reset all mailboxes are free, all flags are 0 and `busStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| orderFifo | input | 1 | 1: request order; 0: lowest identifier first |
| reqValid | input | 1 | Load-and-request strobe |
| reqIdx | input | 2 | Mailbox index of the request |
| reqId | input | 29 | Identifier to load |
| reqExt | input | 1 | 1: 29-bit identifier; 0: 11-bit identifier in bits 10:0 |
| abortReq | input | 3 | Per-mailbox abort strobes |
| busStart | output | 1 | One-cycle pulse: engine starts sending `busIdx` |
| busIdx | output | 2 | Mailbox currently handed to the engine |
| busId | output | 29 | Aligned identifier of that mailbox |
| busDone | input | 1 | Engine reports the end of the current attempt |
| busOk | input | 1 | Outcome qualifier with `busDone`: 1 success |
| mbEmpty | output | 3 | Per-mailbox free indication |
| doneFlag | output | 3 | Per-mailbox request finished (sent or aborted) |
| okFlag | output | 3 | Per-mailbox finished by successful transmission |
| errFlag | output | 3 | Per-mailbox at least one failed attempt |

## Verification
The bench builds the block with its default identifier width of 29 and standard width of 11. At these values the standard identifier lands at bit 18, and the bench places it between two extended identifiers either side of that boundary. With the three mailboxes all pending at once, an engine whose latency the bench controls keeps one frame on the bus while the others queue. This lets the bench reach ordering ties, aborts that arrive during transmission, retries after failure, and queue removal in the middle of the queue.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int MB_NUM   = 3;
  localparam int MB_IDX_W = $clog2(MB_NUM);
  localparam int RANK_W   = $clog2(MB_NUM);

  typedef enum logic [1:0] {
    MB_EMPTY = 2'd0,
    MB_SCHED = 2'd1,
    MB_XMIT  = 2'd2,
    MB_DONE  = 2'd3
  } mbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                loadEn;
    logic [MB_IDX_W-1:0] loadIdx;
    logic [MB_NUM-1:0]   leaveMask;   // leaving the queue this cycle
    logic [MB_NUM-1:0]   queuedMask;  // staying in the queue this cycle
    logic [MB_NUM-1:0]   candMask;    // eligible for selection
  } dpStrobe_t;
endpackage

// File: rtl/can_txmb_dp.sv
module can_txmb_dp
  import can_txmb_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                orderFifo,
  input  logic [ID_W-1:0]     reqId,
  input  logic                reqExt,
  input  dpStrobe_t           strb,
  input  logic [MB_IDX_W-1:0] busIdx,
  output logic                selValid,
  output logic [MB_IDX_W-1:0] selIdx,
  output logic [ID_W-1:0]     busId
);
  localparam int PAD_W = ID_W - STD_W;

  logic [ID_W-1:0]   idMem   [MB_NUM];
  logic [RANK_W-1:0] rank    [MB_NUM];
  logic [RANK_W-1:0] dropCnt [MB_NUM];
  logic [RANK_W-1:0] newRank;
  logic [ID_W-1:0]   alignedId;
  logic [ID_W-1:0]   bestId;
  logic [RANK_W-1:0] bestRank;

  assign alignedId = reqExt ? reqId : {reqId[STD_W-1:0], {PAD_W{1'b0}}};

  // rank of a new entry = number of entries that stay queued
  always_comb begin
    newRank = '0;
    for (int j = 0; j < MB_NUM; j++)
      newRank = newRank + RANK_W'(strb.queuedMask[j]);
  end

  // how many leaving entries sat ahead of each entry
  always_comb begin
    for (int i = 0; i < MB_NUM; i++) begin
      dropCnt[i] = '0;
      for (int j = 0; j < MB_NUM; j++)
        if (strb.leaveMask[j] && (rank[j] < rank[i]))
          dropCnt[i] = dropCnt[i] + RANK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MB_NUM; i++) begin
        idMem[i] <= '0;
        rank[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < MB_NUM; i++) begin
        if (strb.loadEn && (strb.loadIdx == MB_IDX_W'(i))) begin
          idMem[i] <= alignedId;
          rank[i]  <= newRank;
        end else if (strb.queuedMask[i]) begin
          rank[i]  <= rank[i] - dropCnt[i];
        end
      end
    end
  end

  // selector: lowest rank or lowest identifier, strict compare keeps lower index on ties
  always_comb begin
    selValid = 1'b0;
    selIdx   = '0;
    bestId   = '0;
    bestRank = '0;
    for (int i = 0; i < MB_NUM; i++) begin
      if (strb.candMask[i]) begin
        if (!selValid ||
            (orderFifo  && (rank[i]  < bestRank)) ||
            (!orderFifo && (idMem[i] < bestId))) begin
          selValid = 1'b1;
          selIdx   = MB_IDX_W'(i);
          bestId   = idMem[i];
          bestRank = rank[i];
        end
      end
    end
  end

  assign busId = idMem[busIdx];
endmodule

// File: rtl/can_txmb_ctrl.sv
module can_txmb_ctrl
  import can_txmb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [MB_IDX_W-1:0] reqIdx,
  input  logic [MB_NUM-1:0]   abortReq,
  input  logic                busDone,
  input  logic                busOk,
  input  logic                selValid,
  input  logic [MB_IDX_W-1:0] selIdx,
  output dpStrobe_t           strb,
  output logic                busStart,
  output logic [MB_IDX_W-1:0] busIdx,
  output logic [MB_NUM-1:0]   mbEmpty,
  output logic [MB_NUM-1:0]   doneFlag,
  output logic [MB_NUM-1:0]   okFlag,
  output logic [MB_NUM-1:0]   errFlag,
  output logic [MB_NUM-1:0]   xmitMask
);
  mbState_e          st     [MB_NUM];
  mbState_e          stNext [MB_NUM];
  logic [MB_NUM-1:0] schedMask, reqHit, abortHeld, leaveMask, queuedMask;
  logic              startNow;

  always_comb begin
    for (int i = 0; i < MB_NUM; i++) begin
      schedMask[i] = (st[i] == MB_SCHED);
      xmitMask[i]  = (st[i] == MB_XMIT);
      mbEmpty[i]   = (st[i] == MB_EMPTY) || (st[i] == MB_DONE);
      reqHit[i]    = reqValid && (reqIdx == MB_IDX_W'(i)) && mbEmpty[i];
    end
  end

  assign startNow = selValid && !(|xmitMask);

  always_comb begin
    for (int i = 0; i < MB_NUM; i++) begin
      stNext[i] = st[i];
      unique case (st[i])
        MB_EMPTY, MB_DONE: if (reqHit[i]) stNext[i] = MB_SCHED;
        MB_SCHED: begin
          if (abortReq[i])                                  stNext[i] = MB_DONE;
          else if (startNow && (selIdx == MB_IDX_W'(i)))    stNext[i] = MB_XMIT;
        end
        MB_XMIT: begin
          if (busDone) begin
            if (busOk || abortHeld[i] || abortReq[i])       stNext[i] = MB_DONE;
            else                                            stNext[i] = MB_SCHED;
          end
        end
      endcase
      leaveMask[i]  = !mbEmpty[i] && (stNext[i] == MB_DONE);
      queuedMask[i] = !mbEmpty[i] && !leaveMask[i];
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadEn     = |reqHit;
    strb.loadIdx    = reqIdx;
    strb.leaveMask  = leaveMask;
    strb.queuedMask = queuedMask;
    strb.candMask   = schedMask & ~abortReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MB_NUM; i++) st[i] <= MB_EMPTY;
      abortHeld <= '0;
      doneFlag  <= '0;
      okFlag    <= '0;
      errFlag   <= '0;
      busStart  <= 1'b0;
      busIdx    <= '0;
    end else begin
      for (int i = 0; i < MB_NUM; i++) begin
        st[i] <= stNext[i];
        abortHeld[i] <= (xmitMask[i] && !busDone) ? (abortHeld[i] | abortReq[i]) : 1'b0;
        if (reqHit[i]) begin
          doneFlag[i] <= 1'b0;
          okFlag[i]   <= 1'b0;
          errFlag[i]  <= 1'b0;
        end else if (schedMask[i] && abortReq[i]) begin
          doneFlag[i] <= 1'b1;
        end else if (xmitMask[i] && busDone) begin
          if (busOk) begin
            doneFlag[i] <= 1'b1;
            okFlag[i]   <= 1'b1;
          end else begin
            errFlag[i]  <= 1'b1;
            if (abortHeld[i] || abortReq[i]) doneFlag[i] <= 1'b1;
          end
        end
      end
      busStart <= startNow;
      if (startNow) busIdx <= selIdx;
    end
  end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
  import can_txmb_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                orderFifo,
  input  logic                reqValid,
  input  logic [MB_IDX_W-1:0] reqIdx,
  input  logic [ID_W-1:0]     reqId,
  input  logic                reqExt,
  input  logic [MB_NUM-1:0]   abortReq,
  output logic                busStart,
  output logic [MB_IDX_W-1:0] busIdx,
  output logic [ID_W-1:0]     busId,
  input  logic                busDone,
  input  logic                busOk,
  output logic [MB_NUM-1:0]   mbEmpty,
  output logic [MB_NUM-1:0]   doneFlag,
  output logic [MB_NUM-1:0]   okFlag,
  output logic [MB_NUM-1:0]   errFlag
);
  dpStrobe_t           strb;
  logic                selValid;
  logic [MB_IDX_W-1:0] selIdx;
  logic [MB_NUM-1:0]   xmitMask;

  can_txmb_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqIdx   (reqIdx),
    .abortReq (abortReq),
    .busDone  (busDone),
    .busOk    (busOk),
    .selValid (selValid),
    .selIdx   (selIdx),
    .strb     (strb),
    .busStart (busStart),
    .busIdx   (busIdx),
    .mbEmpty  (mbEmpty),
    .doneFlag (doneFlag),
    .okFlag   (okFlag),
    .errFlag  (errFlag),
    .xmitMask (xmitMask)
  );

  can_txmb_dp #(.ID_W(ID_W), .STD_W(STD_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .orderFifo (orderFifo),
    .reqId     (reqId),
    .reqExt    (reqExt),
    .strb      (strb),
    .busIdx    (busIdx),
    .selValid  (selValid),
    .selIdx    (selIdx),
    .busId     (busId)
  );
endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk
  import can_txmb_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [MB_IDX_W-1:0] reqIdx,
  input logic [MB_NUM-1:0]   abortReq,
  input logic                busStart,
  input logic [MB_IDX_W-1:0] busIdx,
  input logic                busDone,
  input logic                busOk,
  input logic [MB_NUM-1:0]   mbEmpty,
  input logic [MB_NUM-1:0]   doneFlag,
  input logic [MB_NUM-1:0]   okFlag,
  input logic [MB_NUM-1:0]   errFlag,
  input logic [MB_NUM-1:0]   xmitMask
);
  p_one_xmit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(xmitMask));

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> !busStart);

  p_start_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> (xmitMask[busIdx] && !mbEmpty[busIdx]));

  p_req_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mbEmpty[reqIdx]) |=> (!mbEmpty[$past(reqIdx)] && !doneFlag[$past(reqIdx)]));

  p_success_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && busOk && (|xmitMask)) |=>
      (doneFlag[$past(busIdx)] && okFlag[$past(busIdx)] && mbEmpty[$past(busIdx)]));

  p_fail_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busDone && !busOk && (|xmitMask)) |=> (errFlag[$past(busIdx)] && !okFlag[$past(busIdx)]));

  for (genvar k = 0; k < MB_NUM; k++) begin : g_mb
    p_abort_sched_r7: assert property (@(posedge clk) disable iff (!rstN)
      (abortReq[k] && !mbEmpty[k] && !xmitMask[k]) |=> (mbEmpty[k] && doneFlag[k] && !okFlag[k]));

    p_abort_held_r8: assert property (@(posedge clk) disable iff (!rstN)
      (abortReq[k] && xmitMask[k] && !busDone) |=> (xmitMask[k] && !mbEmpty[k]));
  end
endmodule

bind can_txmb_sched can_txmb_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqIdx   (reqIdx),
  .abortReq (abortReq),
  .busStart (busStart),
  .busIdx   (busIdx),
  .busDone  (busDone),
  .busOk    (busOk),
  .mbEmpty  (mbEmpty),
  .doneFlag (doneFlag),
  .okFlag   (okFlag),
  .errFlag  (errFlag),
  .xmitMask (xmitMask)
);

// File: tb/can_txmb_sched_tb_top.sv
module can_txmb_sched_tb_top;
  localparam int ID_W = 29;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            orderFifo = 1'b0;
  logic            reqValid = 1'b0;
  logic [1:0]      reqIdx = '0;
  logic [ID_W-1:0] reqId = '0;
  logic            reqExt = 1'b0;
  logic [2:0]      abortReq = '0;
  logic            busStart;
  logic [1:0]      busIdx;
  logic [ID_W-1:0] busId;
  logic            busDone = 1'b0;
  logic            busOk = 1'b0;
  logic [2:0]      mbEmpty, doneFlag, okFlag, errFlag;

  always #4 clk = ~clk;

  can_txmb_sched dut_i (
    .clk(clk), .rstN(rstN), .orderFifo(orderFifo), .reqValid(reqValid),
    .reqIdx(reqIdx), .reqId(reqId), .reqExt(reqExt), .abortReq(abortReq),
    .busStart(busStart), .busIdx(busIdx), .busId(busId), .busDone(busDone),
    .busOk(busOk), .mbEmpty(mbEmpty), .doneFlag(doneFlag), .okFlag(okFlag),
    .errFlag(errFlag)
  );

  typedef struct { logic [1:0] idx; logic [ID_W-1:0] id; } startExp_t;
  startExp_t expQ[$];
  bit        outQ[$];
  int        errs = 0;
  int        checks = 0;
  int        engLat = 4;
  int        engCnt = 0;
  bit        engActive = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // bus engine model
  always @(negedge clk) begin
    bit o;
    if (!rstN) begin
      busDone   <= 1'b0;
      engActive <= 1'b0;
    end else begin
      busDone <= 1'b0;
      if (busStart) begin
        engActive <= 1'b1;
        engCnt    <= engLat;
      end else if (engActive) begin
        if (engCnt <= 1) begin
          o = (outQ.size() > 0) ? outQ.pop_front() : 1'b1;
          busDone   <= 1'b1;
          busOk     <= o;
          engActive <= 1'b0;
        end else begin
          engCnt <= engCnt - 1;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    startExp_t e;
    if (rstN && busStart) begin
      chk(!engActive, "R2 start while engine busy", 64'(engActive), 64'd0);
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected start", 64'(busIdx), 64'hff);
      end else begin
        e = expQ.pop_front();
        chk(busIdx == e.idx, "start order R3 R4 R5 R10 R11", 64'(busIdx), 64'(e.idx));
        chk(busId == e.id, "R6 presented identifier", 64'(busId), 64'(e.id));
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finishRun();
  end

  task automatic pushExp(input logic [1:0] idx, input logic [ID_W-1:0] id);
    startExp_t e;
    e.idx = idx;
    e.id  = id;
    expQ.push_back(e);
  endtask

  task automatic doReq(input logic [1:0] idx, input logic [ID_W-1:0] id, input bit ext);
    reqValid = 1'b1;
    reqIdx   = idx;
    reqId    = id;
    reqExt   = ext;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doAbort(input logic [2:0] m);
    abortReq = m;
    @(negedge clk);
    abortReq = '0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(mbEmpty == 3'b111 && !engActive && !busStart && expQ.size() == 0) && n < 2000);
    chk(n < 2000, {tag, " reached idle"}, 64'(n), 64'd2000);
    chk(expQ.size() == 0, {tag, " all expected starts seen"}, 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(mbEmpty == 3'b111, "R12 all free", 64'(mbEmpty), 64'h7);
    chk(doneFlag == 0 && okFlag == 0 && errFlag == 0, "R12 flags clear",
        64'({doneFlag, okFlag, errFlag}), 64'd0);
    chk(busStart == 1'b0, "R12 no start", 64'(busStart), 64'd0);

    // R3 request order
    orderFifo = 1'b1; engLat = 6;
    pushExp(2, 29'h100); pushExp(0, 29'h50); pushExp(1, 29'h10);
    doReq(2, 29'h100, 1'b1);
    doReq(0, 29'h50, 1'b1);
    doReq(1, 29'h10, 1'b1);
    waitIdle("R3");
    chk(doneFlag == 3'b111 && okFlag == 3'b111, "R8 success flags",
        64'({doneFlag, okFlag}), 64'h3f);

    // R4 lowest identifier first, R1 ignored request
    orderFifo = 1'b0; engLat = 8;
    pushExp(0, 29'h1000); pushExp(2, 29'h200); pushExp(1, 29'h300);
    doReq(0, 29'h1000, 1'b1);
    chk(!mbEmpty[0] && !doneFlag[0] && !okFlag[0], "R1 accepted and flags cleared",
        64'({mbEmpty[0], doneFlag[0], okFlag[0]}), 64'd0);
    doReq(1, 29'h300, 1'b1);
    doReq(2, 29'h200, 1'b1);
    doReq(1, 29'h5, 1'b1);   // R1: mailbox occupied, must be ignored
    waitIdle("R4");

    // R5 tie on identifier
    pushExp(0, 29'h7); pushExp(1, 29'h40); pushExp(2, 29'h40);
    doReq(0, 29'h7, 1'b1);
    doReq(2, 29'h40, 1'b1);
    doReq(1, 29'h40, 1'b1);
    waitIdle("R5");

    // R6 standard identifier alignment, R1 request to mailbox in transmit
    pushExp(0, 29'h1FFFFFFF); pushExp(2, 29'h013FFFF); pushExp(1, 29'h0140000);
    doReq(0, 29'h1FFFFFFF, 1'b1);
    doReq(1, 29'h5, 1'b0);
    doReq(2, 29'h013FFFF, 1'b1);
    doReq(0, 29'h0, 1'b1);   // R1: mailbox 0 on the bus, ignored
    waitIdle("R6");

    // R7 abort of scheduled mailbox
    engLat = 10;
    pushExp(0, 29'h20);
    doReq(0, 29'h20, 1'b1);
    doReq(1, 29'h10, 1'b1);
    doAbort(3'b010);
    chk(mbEmpty[1] && doneFlag[1] && !okFlag[1], "R7 aborted while scheduled",
        64'({mbEmpty[1], doneFlag[1], okFlag[1]}), 64'h6);
    waitIdle("R7");

    // R8 abort held, transmission succeeds
    engLat = 6;
    outQ.push_back(1'b1);
    pushExp(2, 29'h33);
    doReq(2, 29'h33, 1'b1);
    while (!busStart) @(negedge clk);
    doAbort(3'b100);
    chk(!mbEmpty[2], "R8 abort held during transmit", 64'(mbEmpty[2]), 64'd0);
    waitIdle("R8");
    chk(doneFlag[2] && okFlag[2] && !errFlag[2], "R8 success after held abort",
        64'({doneFlag[2], okFlag[2], errFlag[2]}), 64'h6);

    // R9 abort held, transmission fails
    outQ.push_back(1'b0);
    pushExp(1, 29'h44);
    doReq(1, 29'h44, 1'b1);
    while (!busStart) @(negedge clk);
    doAbort(3'b010);
    waitIdle("R9");
    chk(mbEmpty[1] && doneFlag[1] && !okFlag[1] && errFlag[1], "R9 failed with held abort",
        64'({mbEmpty[1], doneFlag[1], okFlag[1], errFlag[1]}), 64'hd);

    // R10 retry after failure, R2 start latency
    engLat = 3;
    outQ.push_back(1'b0); outQ.push_back(1'b1);
    pushExp(0, 29'h9); pushExp(0, 29'h9);
    doReq(0, 29'h9, 1'b1);
    chk(busStart == 1'b0, "R2 no start one cycle after request", 64'(busStart), 64'd0);
    @(negedge clk);
    chk(busStart == 1'b1, "R2 start two cycles after request", 64'(busStart), 64'd1);
    waitIdle("R10");
    chk(doneFlag[0] && okFlag[0] && errFlag[0], "R10 retried and succeeded",
        64'({doneFlag[0], okFlag[0], errFlag[0]}), 64'h7);

    // R10 retry keeps its place in request order
    orderFifo = 1'b1; engLat = 8;
    outQ.push_back(1'b0);
    pushExp(1, 29'h400); pushExp(1, 29'h400); pushExp(2, 29'h500); pushExp(0, 29'h100);
    doReq(1, 29'h400, 1'b1);
    doReq(2, 29'h500, 1'b1);
    doReq(0, 29'h100, 1'b1);
    waitIdle("R10 order");

    // R11 removal keeps order of the rest
    engLat = 12;
    pushExp(0, 29'h700); pushExp(2, 29'h300); pushExp(1, 29'h100);
    doReq(0, 29'h700, 1'b1);
    doReq(1, 29'h100, 1'b1);
    doReq(2, 29'h300, 1'b1);
    doAbort(3'b010);
    doReq(1, 29'h100, 1'b1);
    waitIdle("R11");

    finishRun();
  end
endmodule